// File: doc/BRIEF.md
# Bank-Aware Marginal Utility Allocator

This engine turns a set of per-core hit histograms into a capacity plan for a shared last-level cache. The cache is built from sixteen banks of eight ways each. Eight of the banks are local, one beside each core. The other eight are central banks that any core may own. The histograms are collected over a profiling interval. Entry `k` of core `c` gives the extra hits that core would gain by growing from `k` ways to `k+1` ways.

A run is started with a one-cycle `start_i` pulse. Each core first gets one way. The engine then spends one cycle per remaining way on a greedy pass. In each cycle the next way goes to the core whose next way brings the most extra hits. The result is then rounded into a shape the banks can hold. Central banks are handed out whole, one per cycle, to the core that is furthest below its greedy target. A core that owns central banks keeps its entire local bank. A pair of neighbouring cores that owns no central bank may split one of its two local banks between them. When the plan is ready, `done_o` rises and every output holds its value until the next start.

The histogram input must stay stable while a run is in progress. Collecting the histograms and applying the plan to the cache are done elsewhere.

Top module: `bank_util_alloc`

## Requirements
- R1: After reset, `done_o` is 0 and every plan output (`ways_o`, `owner_o`, `ncen_o`, `own_o`, `borrow_o`, `split_o`) is 0.
- R2: The greedy pass starts at 1 way per core and grants 120 single ways. Each grant goes to the core with the largest `hist_i[c][w]`, where `w` is that core's current way count; an index at or above HDEPTH counts as 0. Ties go to the lowest core index. `ways_o[c]` holds the final count.
- R3: At completion, the `ways_o` entries sum to 128 and each entry is at least 1.
- R4: Central banks are granted in bank order 0 to 7. Each bank goes to the core with the largest signed deficit `ways - 8 - 8*granted_so_far`, with ties to the lowest core. `owner_o[k]` is the index of the core that owns central bank `k`.
- R5: `ncen_o[c]` equals the number of central banks whose `owner_o` is `c`. A core with `ncen_o` above 0 has `own_o = 8` and `borrow_o = 0`.
- R6: Neighbours are cores `2p` and `2p+1`. If either core of a pair owns a central bank, both cores have `own_o = 8` and `borrow_o = 0`, and `split_o[p] = 0`.
- R7: If neither core of pair `p` owns a central bank, let `d = clamp(8 + floor((ways[2p] - ways[2p+1]) / 2), 1, 15)`.
  - If `d <= 8`: the even core has own `d` and borrow 0; the odd core has own 8 and borrow `8 - d`.
  - Otherwise: the even core has own 8 and borrow `d - 8`; the odd core has own `16 - d` and borrow 0.
  - In both cases `split_o[p] = (d != 8)`.
- R8: At completion, `own + borrow + 8*ncen` summed over all cores equals 128, and every core has `own_o >= 1`.
- R9: `done_o` goes to 0 in the cycle after a start is accepted. It rises exactly 129 rising edges after the edge that accepts `start_i`.
- R10: `start_i` has no effect while a run is in progress; the run completes with the original timing and results.
- R11: While `done_o` is 1 and no start is given, all outputs hold their values, even when `hist_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| hist_i | input | N_CORE*HDEPTH*HW (1536) | Marginal-hit histograms, `[core][ways][count]` |
| done_o | output | 1 | Plan complete and held |
| ways_o | output | N_CORE*AW (64) | Greedy way count per core |
| owner_o | output | N_CENTRAL*CW (24) | Owning core of each central bank |
| ncen_o | output | N_CORE*NW (32) | Central banks per core |
| own_o | output | N_CORE*WW (32) | Ways a core uses in its own local bank |
| borrow_o | output | N_CORE*WW (32) | Ways a core uses in its neighbour's local bank |
| split_o | output | N_CORE/2 (4) | Local bank of the pair is split |

## Verification
The bench sweeps several histogram families:
- all-zero histograms, where every tie must fall to core 0, which then takes every central bank;
- identical decaying histograms, which stress the lowest-index tie rule round-robin;
- random entries;
- skewed histograms that force central grants and local splits.

A wrong tie order would shift ways between cores and change the greedy counts. An off-by-one in the histogram index would pick the wrong marginal value. A non-floor halving in the split would give odd-difference pairs one way too many or too few. A core granted central banks while still lending part of its local bank would break the full-local rule.

A start pulse in the middle of a run checks that a busy engine is not restarted. Changing the histograms after completion checks that the held plan does not drift.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GREEDY,
    ST_CENTRAL,
    ST_LOCAL,
    ST_DONE
  } bmu_state_e;
endpackage

// File: rtl/bmu_argmax.sv
// Signed maximum over N candidates; ties resolve to the lowest index.
module bmu_argmax #(
  parameter int N  = 8,
  parameter int W  = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] val_i,
  output logic [IW-1:0]       idx_o
);
  logic signed [W-1:0] best;

  always_comb begin
    idx_o = '0;
    best  = $signed(val_i[0]);
    for (int i = 1; i < N; i++) begin
      if ($signed(val_i[i]) > best) begin
        best  = $signed(val_i[i]);
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bmu_pair_split.sv
// Divides the two local banks of a neighbour pair.
module bmu_pair_split #(
  parameter int WAYS = 8,
  parameter int AW   = 8,
  parameter int WW   = 4
) (
  input  logic [AW-1:0] a_ev_i,
  input  logic [AW-1:0] a_od_i,
  input  logic          cen_ev_i,
  input  logic          cen_od_i,
  output logic [WW-1:0] own_ev_o,
  output logic [WW-1:0] own_od_o,
  output logic [WW-1:0] bor_ev_o,
  output logic [WW-1:0] bor_od_o,
  output logic          split_o
);
  localparam int SW = AW + 2;
  localparam logic [WW-1:0] WFULL = WW'(WAYS);
  localparam logic [WW-1:0] WPAIR = WW'(2 * WAYS);

  logic signed [SW-1:0] diff, mid, cl;
  logic [WW-1:0] dc;

  assign diff = $signed({2'b00, a_ev_i}) - $signed({2'b00, a_od_i});
  assign mid  = (diff >>> 1) + $signed(SW'(WAYS));

  always_comb begin
    if (mid < $signed(SW'(1)))                 cl = $signed(SW'(1));
    else if (mid > $signed(SW'(2 * WAYS - 1))) cl = $signed(SW'(2 * WAYS - 1));
    else                                       cl = mid;
  end

  assign dc = cl[WW-1:0];

  always_comb begin
    own_ev_o = WFULL;
    own_od_o = WFULL;
    bor_ev_o = '0;
    bor_od_o = '0;
    split_o  = 1'b0;
    if (!cen_ev_i && !cen_od_i) begin
      if (dc <= WFULL) begin
        own_ev_o = dc;
        bor_od_o = WFULL - dc;
      end else begin
        bor_ev_o = dc - WFULL;
        own_od_o = WPAIR - dc;
      end
      split_o = (dc != WFULL);
    end
  end
endmodule

// File: rtl/bank_util_alloc.sv
module bank_util_alloc
  import bmu_pkg::*;
#(
  parameter int N_CORE    = 8,
  parameter int N_CENTRAL = 8,
  parameter int WAYS      = 8,
  parameter int HDEPTH    = 24,
  parameter int HW        = 8,
  localparam int TOTAL = (N_CORE + N_CENTRAL) * WAYS,
  localparam int AW    = $clog2(TOTAL + 1),
  localparam int CW    = $clog2(N_CORE),
  localparam int NW    = $clog2(N_CENTRAL + 1),
  localparam int WW    = $clog2(2 * WAYS),
  localparam int NPAIR = N_CORE / 2
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    start_i,
  input  logic [N_CORE-1:0][HDEPTH-1:0][HW-1:0]   hist_i,
  output logic                                    done_o,
  output logic [N_CORE-1:0][AW-1:0]               ways_o,
  output logic [N_CENTRAL-1:0][CW-1:0]            owner_o,
  output logic [N_CORE-1:0][NW-1:0]               ncen_o,
  output logic [N_CORE-1:0][WW-1:0]               own_o,
  output logic [N_CORE-1:0][WW-1:0]               borrow_o,
  output logic [NPAIR-1:0]                        split_o
);
  localparam int STEPS = TOTAL - N_CORE;
  localparam int SCW   = $clog2(STEPS + 1);
  localparam int VW    = ((HW > AW) ? HW : AW) + 2;
  localparam int SUMW  = AW + CW;

  bmu_state_e state_q;
  logic [SCW-1:0] step_q;
  logic [N_CORE-1:0][AW-1:0]    alloc_q;
  logic [N_CORE-1:0][NW-1:0]    ncen_q;
  logic [N_CENTRAL-1:0][CW-1:0] owner_q;
  logic [N_CORE-1:0][WW-1:0]    own_q, bor_q, own_d, bor_d;
  logic [NPAIR-1:0]             split_q, split_d;

  logic [N_CORE-1:0][VW-1:0] gain, defc, cand;
  logic [CW-1:0] win;
  logic accept;

  assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  // Candidate metric: marginal hits in greedy phase, signed deficit in central phase
  always_comb begin
    for (int c = 0; c < N_CORE; c++) begin
      gain[c] = '0;
      for (int k = 0; k < HDEPTH; k++)
        if (alloc_q[c] == AW'(k)) gain[c] = VW'(hist_i[c][k]);
      defc[c] = VW'(alloc_q[c]) - VW'(WAYS) - VW'(ncen_q[c]) * VW'(WAYS);
      cand[c] = (state_q == ST_GREEDY) ? gain[c] : defc[c];
    end
  end

  bmu_argmax #(.N(N_CORE), .W(VW)) u_pick (
    .val_i(cand),
    .idx_o(win)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    bmu_pair_split #(.WAYS(WAYS), .AW(AW), .WW(WW)) u_split (
      .a_ev_i  (alloc_q[2*p]),
      .a_od_i  (alloc_q[2*p+1]),
      .cen_ev_i(ncen_q[2*p] != '0),
      .cen_od_i(ncen_q[2*p+1] != '0),
      .own_ev_o(own_d[2*p]),
      .own_od_o(own_d[2*p+1]),
      .bor_ev_o(bor_d[2*p]),
      .bor_od_o(bor_d[2*p+1]),
      .split_o (split_d[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      alloc_q <= '0;
      ncen_q  <= '0;
      owner_q <= '0;
      own_q   <= '0;
      bor_q   <= '0;
      split_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_GREEDY;
            step_q  <= '0;
            for (int c = 0; c < N_CORE; c++) alloc_q[c] <= AW'(1);
            ncen_q  <= '0;
            owner_q <= '0;
            own_q   <= '0;
            bor_q   <= '0;
            split_q <= '0;
          end
        end
        ST_GREEDY: begin
          for (int c = 0; c < N_CORE; c++)
            if (win == CW'(c)) alloc_q[c] <= alloc_q[c] + AW'(1);
          if (step_q == SCW'(STEPS - 1)) begin
            state_q <= ST_CENTRAL;
            step_q  <= '0;
          end else begin
            step_q <= step_q + SCW'(1);
          end
        end
        ST_CENTRAL: begin
          for (int k = 0; k < N_CENTRAL; k++)
            if (step_q == SCW'(k)) owner_q[k] <= win;
          for (int c = 0; c < N_CORE; c++)
            if (win == CW'(c)) ncen_q[c] <= ncen_q[c] + NW'(1);
          if (step_q == SCW'(N_CENTRAL - 1)) state_q <= ST_LOCAL;
          step_q <= step_q + SCW'(1);
        end
        ST_LOCAL: begin
          own_q   <= own_d;
          bor_q   <= bor_d;
          split_q <= split_d;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = (state_q == ST_DONE);
  assign ways_o   = alloc_q;
  assign owner_o  = owner_q;
  assign ncen_o   = ncen_q;
  assign own_o    = own_q;
  assign borrow_o = bor_q;
  assign split_o  = split_q;

  logic [SUMW-1:0] ways_sum;
  always_comb begin
    ways_sum = '0;
    for (int c = 0; c < N_CORE; c++) ways_sum = ways_sum + SUMW'(alloc_q[c]);
  end

  a_r3_ways_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ways_sum == SUMW'(TOTAL));

  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !done_o && state_q == ST_GREEDY);

  a_r10_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GREEDY && step_q != SCW'(STEPS - 1)) |=> state_q == ST_GREEDY);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(alloc_q) && $stable(owner_q)
                             && $stable(ncen_q) && $stable(own_q) && $stable(bor_q)
                             && $stable(split_q));

  for (genvar c = 0; c < N_CORE; c++) begin : g_core_chk
    a_r5_full_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && ncen_q[c] != '0) |-> own_q[c] == WW'(WAYS) && bor_q[c] == '0);
    a_r8_min_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> own_q[c] != '0 && alloc_q[c] != '0);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
    a_r7_pair_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (WW+2)'(own_q[2*p]) + (WW+2)'(bor_q[2*p]) + (WW+2)'(own_q[2*p+1])
                 + (WW+2)'(bor_q[2*p+1]) == (WW+2)'(2 * WAYS));
  end
endmodule

// File: tb/bank_util_alloc_test.sv
`timescale 1ns/1ps
module bank_util_alloc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0][23:0][7:0] hist;
  logic done;
  logic [7:0][7:0] ways;
  logic [7:0][2:0] owner;
  logic [7:0][3:0] ncen, own, borrow;
  logic [3:0] split;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned seed = 32'h1234_5678;

  int m_ways[8], m_owner[8], m_ncen[8], m_own[8], m_bor[8], m_split[4];

  always #10 clk = ~clk;

  bank_util_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hist_i(hist),
    .done_o(done), .ways_o(ways), .owner_o(owner), .ncen_o(ncen),
    .own_o(own), .borrow_o(borrow), .split_o(split)
  );

  task automatic chk(string tag, int idx, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s idx %0d: got %0d expected %0d", tag, idx, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  task automatic fill(int mode);
    int hot;
    hot = rnd() % 8;
    for (int c = 0; c < 8; c++) begin
      int base;
      base = rnd();
      for (int k = 0; k < 24; k++) begin
        case (mode)
          0: hist[c][k] = 8'd0;
          1: hist[c][k] = (200 - 8 * k > 0) ? 8'(200 - 8 * k) : 8'd0;
          2: hist[c][k] = 8'(rnd());
          3: hist[c][k] = 8'(base >> (k / 3));
          default: hist[c][k] = (c == hot) ? 8'd250 : 8'(rnd() & 15);
        endcase
      end
    end
  endtask

  // Expected plan computed from the requirement text
  task automatic model();
    for (int c = 0; c < 8; c++) begin m_ways[c] = 1; m_ncen[c] = 0; end
    repeat (120) begin
      int best, bi;
      best = -1; bi = 0;
      for (int c = 0; c < 8; c++) begin
        int g;
        g = (m_ways[c] < 24) ? int'(hist[c][m_ways[c]]) : 0;
        if (g > best) begin best = g; bi = c; end
      end
      m_ways[bi]++;
    end
    for (int k = 0; k < 8; k++) begin
      int best, bi;
      best = -100000; bi = 0;
      for (int c = 0; c < 8; c++) begin
        int d;
        d = m_ways[c] - 8 - 8 * m_ncen[c];
        if (d > best) begin best = d; bi = c; end
      end
      m_owner[k] = bi;
      m_ncen[bi]++;
    end
    for (int p = 0; p < 4; p++) begin
      int e, o, diff, d;
      e = 2 * p; o = 2 * p + 1;
      m_own[e] = 8; m_own[o] = 8; m_bor[e] = 0; m_bor[o] = 0; m_split[p] = 0;
      if (m_ncen[e] == 0 && m_ncen[o] == 0) begin
        diff = m_ways[e] - m_ways[o];
        d = 8 + (diff >>> 1);
        if (d < 1) d = 1;
        if (d > 15) d = 15;
        if (d <= 8) begin m_own[e] = d; m_bor[o] = 8 - d; end
        else begin m_bor[e] = d - 8; m_own[o] = 16 - d; end
        m_split[p] = (d != 8);
      end
    end
  endtask

  task automatic compare(bit hold);
    int tot, wsum;
    tot = 0; wsum = 0;
    for (int c = 0; c < 8; c++) begin
      bit cen_pair;
      cen_pair = (m_ncen[c & 6] != 0) || (m_ncen[c | 1] != 0);
      chk(hold ? "R11" : "R2", c, int'(ways[c]), m_ways[c]);
      chk(hold ? "R11" : "R4", c, int'(owner[c]), m_owner[c]);
      chk(hold ? "R11" : "R5", c, int'(ncen[c]), m_ncen[c]);
      chk(hold ? "R11" : (cen_pair ? "R6" : "R7"), c, int'(own[c]), m_own[c]);
      chk(hold ? "R11" : (cen_pair ? "R6" : "R7"), c, int'(borrow[c]), m_bor[c]);
      chk("R3", c, int'(ways[c] >= 1), 1);
      chk("R8", c, int'(own[c] >= 1), 1);
      tot += int'(own[c]) + int'(borrow[c]) + 8 * int'(ncen[c]);
      wsum += int'(ways[c]);
    end
    for (int p = 0; p < 4; p++) chk(hold ? "R11" : "R7", p, int'(split[p]), m_split[p]);
    chk("R8", 99, tot, 128);
    chk("R3", 99, wsum, 128);
  endtask

  task automatic run(int mode, bit mid);
    int k;
    fill(mode);
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9", 0, int'(done), 0);
    k = 0;
    while (!done && k < 400) begin
      @(posedge clk); k++;
      @(negedge clk);
      start = (mid && k == 50);
    end
    start = 1'b0;
    chk(mid ? "R10" : "R9", mode, k, 129);
    compare(1'b0);
    for (int c = 0; c < 8; c++)
      for (int j = 0; j < 24; j++) hist[c][j] = 8'(rnd());
    repeat (20) @(negedge clk);
    chk("R11", 0, int'(done), 1);
    compare(1'b1);
  endtask

  initial begin
    #(20.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk("R1", 0, int'(done), 0);
    chk("R1", 1, int'(ways), 0);
    chk("R1", 2, int'(owner), 0);
    chk("R1", 3, int'(ncen), 0);
    chk("R1", 4, int'(own) | int'(borrow) | int'(split), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 5, int'(done), 0);
    run(0, 1'b0);
    run(1, 1'b0);
    for (int i = 0; i < 30; i++) run(2 + (i % 3), i == 5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule